// File: doc/BRIEF.md
# Paged SPI Register Access Master

This block turns one host request into the full series of SPI frames needed to read or write a register in a target whose register space is split into pages. A request carries a page number, a register offset, a direction, a byte length and up to 64 bits of write data. The block drives chip select, serial clock and MOSI, samples MISO, and ends with a one-cycle completion pulse that carries an error flag and a code.

Each access first polls the target's status register until its busy flag is clear, then writes the page selector. A write then sends one frame with the register offset and the data, least significant byte first. A read sends a one-byte dummy read of the offset, then polls the status register until the read-acknowledge flag is set. It then fetches the bytes through a fixed data window and packs them little-endian into the result. Both polls are bounded and wait a programmable number of clock cycles between attempts.

Top module: `paged_spi_master`

## Requirements
- R1: Every frame starts with a command byte of 0x60 for a read or 0x61 for a write, followed by an offset byte. While bytes are being received the block sends zeros on MOSI.
- R2: Before the page write, a status frame is sent: 0x60, 0xFE, then one byte received. The block goes on once bit 7 of that byte is 0. At most POLL_TRIES status frames are sent, with PAUSE_CYCLES clocks between them. If bit 7 is still 1 after the last one, the request ends with err_code 1 and no further frame.
- R3: Once the busy flag clears, the page is selected with the three-byte frame 0x61, 0xFF, page.
- R4: A write then sends 0x61, offset and exactly req_len data bytes, lowest byte first. For a length of 6 this is the low 48 bits.
- R5: A read then sends 0x60, offset and one received byte. It then polls status frames (0x60, 0xFE and one received byte) until bit 5 is 1, with at most POLL_TRIES attempts and PAUSE_CYCLES clocks between them. If bit 5 never sets, the request ends with err_code 2.
- R6: After the acknowledge, a read sends 0x60, 0xF0 and receives req_len bytes. The first byte received goes to rd_data[7:0], the next to [15:8], and so on. Bits above 8*req_len read as zero.
- R7: A req_len other than 1, 2, 4, 6 or 8 completes on the next clock with done, err and err_code 3, and sends no frame.
- R8: spi_cs_n is low for the whole of each frame and high between frames. spi_sclk is low whenever spi_cs_n is high (SPI mode 0: MOSI changes on the falling edge and MISO is sampled on the rising edge).
- R9: busy is high from the clock after a request is accepted until done pulses. done and busy are never high together, and a req_valid seen while busy has no effect. A successful request ends with err low and err_code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_page | input | 8 | Page number |
| req_reg | input | 8 | Register offset within the page |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, little-endian |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |
| err_code | output | 2 | 0 ok, 1 busy poll timeout, 2 acknowledge timeout, 3 bad length |
| rd_data | output | 64 | Read result, updated when a read completes |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to target |
| spi_miso | input | 1 | Serial data from target |

## Verification
The bench models the target at the pin level and records every frame. It then drives both polls right up to their limits: the busy flag clears on the last allowed try in one case and never clears in another, and the acknowledge is withheld for several tries and then for all of them. An off-by-one retry counter shows up as an extra or missing status frame, or as a wrong error code. The 6-byte read uses a target that would return eight bytes of all ones, so a packer that clocks too many bytes or fails to clear the upper bits shows nonzero high bytes. A wrong byte order in the write payload or the read packing shows as swapped bytes. Illegal lengths and a request sent while busy check that nothing reaches the bus when nothing should.

// File: rtl/psm_pkg.sv
package psm_pkg;
  localparam logic [7:0] CMD_RD      = 8'h60;
  localparam logic [7:0] CMD_WR      = 8'h61;
  localparam logic [7:0] REG_STATUS  = 8'hFE;
  localparam logic [7:0] REG_PAGESEL = 8'hFF;
  localparam logic [7:0] REG_WINDOW  = 8'hF0;
  localparam int         BUSY_BIT    = 7;
  localparam int         RACK_BIT    = 5;
  localparam int         MAX_BYTES   = 10;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_BUSY_TMO = 2'd1,
    ERR_ACK_TMO  = 2'd2,
    ERR_BAD_LEN  = 2'd3
  } psm_err_e;

  typedef enum logic [2:0] {
    PH_BUSY, PH_PAGE, PH_WRITE, PH_DUMMY, PH_ACK, PH_DATA
  } psm_phase_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_LAUNCH, SQ_WAIT, SQ_PAUSE
  } psm_state_e;
endpackage

// File: rtl/psm_pause_timer.sv
module psm_pause_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic fire
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

  logic          run_q, run_d, fire_q, fire_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      if (cnt_q == CW'(CYCLES - 1)) begin
        run_d  = 1'b0;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;

  // R2: the pause ends only once the counter has stopped running
  p_fire_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !run_q);
endmodule

// File: rtl/psm_shifter.sv
module psm_shifter #(
  parameter int CLK_DIV = 4,
  parameter int NBYTES  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        nbytes,
  input  logic [8*NBYTES-1:0] tx_frame,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              rx_valid,
  output logic [7:0]        rx_byte,
  output logic [3:0]        rx_idx,
  output logic              frame_done
);
  localparam int FW = 8 * NBYTES;
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV + 1) : 1;

  typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_GAP} sh_state_e;

  sh_state_e      st_q, st_d;
  logic [DW-1:0]  div_q, div_d;
  logic           sclk_q, sclk_d;
  logic [FW-1:0]  sr_q, sr_d;
  logic [2:0]     bit_q, bit_d;
  logic [3:0]     byte_q, byte_d, nb_q, nb_d;
  logic [7:0]     rsr_q, rsr_d;
  logic           rxv_q, rxv_d, fd_q, fd_d;
  logic [7:0]     rxb_q, rxb_d;
  logic [3:0]     rxi_q, rxi_d;
  logic           tick;

  assign tick = (div_q == DW'(CLK_DIV - 1));

  always_comb begin
    st_d = st_q; div_d = div_q; sclk_d = sclk_q; sr_d = sr_q;
    bit_d = bit_q; byte_d = byte_q; nb_d = nb_q; rsr_d = rsr_q;
    rxv_d = 1'b0; fd_d = 1'b0; rxb_d = rxb_q; rxi_d = rxi_q;
    case (st_q)
      SH_IDLE: if (start) begin
        st_d = SH_RUN; sr_d = tx_frame; nb_d = nbytes;
        bit_d = '0; byte_d = '0; div_d = '0; sclk_d = 1'b0;
      end
      SH_RUN: begin
        div_d = tick ? '0 : div_q + DW'(1);
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rsr_d  = {rsr_q[6:0], miso};
          end else begin
            sclk_d = 1'b0;
            sr_d   = {sr_q[FW-2:0], 1'b0};
            bit_d  = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              rxv_d  = 1'b1;
              rxb_d  = rsr_q;
              rxi_d  = byte_q;
              byte_d = byte_q + 4'd1;
              if (byte_q == nb_q - 4'd1) st_d = SH_GAP;
            end
          end
        end
      end
      default: begin
        div_d = tick ? '0 : div_q + DW'(1);
        if (tick) begin
          st_d = SH_IDLE;
          fd_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SH_IDLE; div_q <= '0; sclk_q <= 1'b0; sr_q <= '0;
      bit_q <= '0; byte_q <= '0; nb_q <= '0; rsr_q <= '0;
      rxv_q <= 1'b0; fd_q <= 1'b0; rxb_q <= '0; rxi_q <= '0;
    end else begin
      st_q <= st_d; div_q <= div_d; sclk_q <= sclk_d; sr_q <= sr_d;
      bit_q <= bit_d; byte_q <= byte_d; nb_q <= nb_d; rsr_q <= rsr_d;
      rxv_q <= rxv_d; fd_q <= fd_d; rxb_q <= rxb_d; rxi_q <= rxi_d;
    end
  end

  assign cs_n       = (st_q != SH_RUN);
  assign sclk       = sclk_q;
  assign mosi       = sr_q[FW-1];
  assign rx_valid   = rxv_q;
  assign rx_byte    = rxb_q;
  assign rx_idx     = rxi_q;
  assign frame_done = fd_q;

  // R8: mode 0 idle level, clock never high outside a frame
  p_sclk_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R8: a frame reports completion only after select is released
  p_frame_end_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> cs_n);
endmodule

// File: rtl/paged_spi_master.sv
module paged_spi_master #(
  parameter int CLK_DIV      = 4,
  parameter int POLL_TRIES   = 10,
  parameter int PAUSE_CYCLES = 250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_page,
  input  logic [7:0]  req_reg,
  input  logic [3:0]  req_len,
  input  logic [63:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [1:0]  err_code,
  output logic [63:0] rd_data,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  import psm_pkg::*;

  localparam int FW    = 8 * MAX_BYTES;
  localparam int TRY_W = $clog2(POLL_TRIES + 1);

  psm_state_e      state_q, state_d;
  psm_phase_e      phase_q, phase_d;
  logic [TRY_W-1:0] tries_q, tries_d;
  logic            wr_q;
  logic [7:0]      page_q, reg_q;
  logic [3:0]      len_q;
  logic [63:0]     wdata_q, acc_q, rd_q;
  logic            bflag_q, aflag_q;
  logic            done_q, done_d, err_q, err_d;
  psm_err_e        code_q, code_d;
  logic            accept, sh_start, pause_start, pause_fire;
  logic [FW-1:0]   tx_frame;
  logic [3:0]      nbytes;
  logic            rx_valid, frame_done;
  logic [7:0]      rx_byte;
  logic [3:0]      rx_idx;
  logic [2:0]      slot;

  function automatic logic len_ok(input logic [3:0] n);
    return (n == 4'd1) || (n == 4'd2) || (n == 4'd4) || (n == 4'd6) || (n == 4'd8);
  endfunction

  assign accept = (state_q == SQ_IDLE) && req_valid && len_ok(req_len);
  assign slot   = 3'(rx_idx - 4'd2);

  // frame composition for the current phase
  always_comb begin
    tx_frame = '0;
    nbytes   = 4'd3;
    case (phase_q)
      PH_PAGE:  tx_frame[FW-1 -: 24] = {CMD_WR, REG_PAGESEL, page_q};
      PH_WRITE: begin
        tx_frame[FW-1 -: 16] = {CMD_WR, reg_q};
        for (int k = 0; k < 8; k++) tx_frame[FW-17-8*k -: 8] = wdata_q[8*k +: 8];
        nbytes = 4'd2 + len_q;
      end
      PH_DUMMY: tx_frame[FW-1 -: 16] = {CMD_RD, reg_q};
      PH_DATA: begin
        tx_frame[FW-1 -: 16] = {CMD_RD, REG_WINDOW};
        nbytes = 4'd2 + len_q;
      end
      default:  tx_frame[FW-1 -: 16] = {CMD_RD, REG_STATUS};
    endcase
  end

  // sequencer next state
  always_comb begin
    state_d = state_q; phase_d = phase_q; tries_d = tries_q;
    done_d = 1'b0; err_d = 1'b0; code_d = code_q;
    sh_start = 1'b0; pause_start = 1'b0;
    case (state_q)
      SQ_IDLE: if (req_valid) begin
        if (len_ok(req_len)) begin
          state_d = SQ_LAUNCH; phase_d = PH_BUSY; tries_d = '0;
        end else begin
          done_d = 1'b1; err_d = 1'b1; code_d = ERR_BAD_LEN;
        end
      end
      SQ_LAUNCH: begin
        sh_start = 1'b1;
        state_d  = SQ_WAIT;
      end
      SQ_WAIT: if (frame_done) begin
        state_d = SQ_LAUNCH;
        case (phase_q)
          PH_BUSY, PH_ACK: begin
            if ((phase_q == PH_BUSY) ? !bflag_q : aflag_q) begin
              phase_d = (phase_q == PH_BUSY) ? PH_PAGE : PH_DATA;
            end else if (tries_q == TRY_W'(POLL_TRIES - 1)) begin
              state_d = SQ_IDLE; done_d = 1'b1; err_d = 1'b1;
              code_d  = (phase_q == PH_BUSY) ? ERR_BUSY_TMO : ERR_ACK_TMO;
            end else begin
              tries_d = tries_q + TRY_W'(1);
              state_d = SQ_PAUSE; pause_start = 1'b1;
            end
          end
          PH_PAGE:  phase_d = wr_q ? PH_WRITE : PH_DUMMY;
          PH_DUMMY: begin
            phase_d = PH_ACK; tries_d = '0;
          end
          default: begin
            state_d = SQ_IDLE; done_d = 1'b1; code_d = ERR_NONE;
          end
        endcase
      end
      default: if (pause_fire) state_d = SQ_LAUNCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE; phase_q <= PH_BUSY; tries_q <= '0;
      wr_q <= 1'b0; page_q <= '0; reg_q <= '0; len_q <= '0; wdata_q <= '0;
      acc_q <= '0; rd_q <= '0; bflag_q <= 1'b0; aflag_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; code_q <= ERR_NONE;
    end else begin
      state_q <= state_d; phase_q <= phase_d; tries_q <= tries_d;
      done_q <= done_d; err_q <= err_d; code_q <= code_d;
      if (accept) begin
        wr_q <= req_write; page_q <= req_page; reg_q <= req_reg;
        len_q <= req_len; wdata_q <= req_wdata; acc_q <= '0;
      end
      if (rx_valid && rx_idx == 4'd2) begin
        bflag_q <= rx_byte[BUSY_BIT];
        aflag_q <= rx_byte[RACK_BIT];
      end
      if (rx_valid && phase_q == PH_DATA && rx_idx >= 4'd2)
        acc_q[{slot, 3'b000} +: 8] <= rx_byte;
      if (state_q == SQ_WAIT && frame_done && phase_q == PH_DATA)
        rd_q <= acc_q;
    end
  end

  psm_shifter #(.CLK_DIV(CLK_DIV), .NBYTES(MAX_BYTES)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .nbytes(nbytes),
    .tx_frame(tx_frame), .miso(spi_miso), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .mosi(spi_mosi), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_idx(rx_idx),
    .frame_done(frame_done)
  );

  psm_pause_timer #(.CYCLES(PAUSE_CYCLES)) u_pause (
    .clk(clk), .rst_n(rst_n), .start(pause_start), .fire(pause_fire)
  );

  assign busy     = (state_q != SQ_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign err_code = code_q;
  assign rd_data  = rd_q;

  // R9: completion and busy are exclusive
  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9: the bus stays quiet whenever no request is in progress
  p_idle_bus_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
  // R7: an error is only ever reported with completion
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R2: a pause is only entered from a finished frame, never during one
  p_pause_after_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pause_start |-> frame_done);
endmodule

// File: tb/test_paged_spi_master.sv
module test_paged_spi_master;
  localparam int TRIES = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_page = '0, req_reg = '0;
  logic [3:0]  req_len = '0;
  logic [63:0] req_wdata = '0;
  logic        busy, done, err, spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [1:0]  err_code;
  logic [63:0] rd_data;

  always #2 clk = ~clk;

  paged_spi_master #(.CLK_DIV(2), .POLL_TRIES(TRIES), .PAUSE_CYCLES(16)) i_paged_spi_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_page(req_page), .req_reg(req_reg), .req_len(req_len), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .err_code(err_code), .rd_data(rd_data),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int total = 0, bad = 0, viol = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // behavioural target model
  logic [7:0]  stat_q[$];
  logic [63:0] slave_rd = '0;
  bit          out_q[$];
  logic [79:0] cur_bits = '0;
  int          cur_len = 0, in_n = 0;
  logic [7:0]  in_b = '0;
  logic [79:0] got_bits[$], exp_bits[$];
  int          got_len[$], exp_len[$];

  task automatic push_byte_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) out_q.push_back(b[i]);
  endtask

  always @(negedge spi_cs_n) begin
    in_n = 0; cur_bits = '0; cur_len = 0; out_q.delete(); spi_miso = 1'b0;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    in_b = {in_b[6:0], spi_mosi};
    in_n++;
    if (in_n == 8) begin
      in_n = 0;
      cur_bits = {cur_bits[71:0], in_b};
      cur_len++;
      if (cur_len == 2 && cur_bits[15:8] == 8'h60) begin
        if (cur_bits[7:0] == 8'hFE) begin
          if (stat_q.size() > 0) push_byte_bits(stat_q.pop_front());
          else push_byte_bits(8'h20);
        end else if (cur_bits[7:0] == 8'hF0) begin
          for (int k = 0; k < 8; k++) push_byte_bits(slave_rd[8*k +: 8]);
        end
      end
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n)
    spi_miso = (out_q.size() > 0) ? out_q.pop_front() : 1'b0;

  always @(posedge spi_cs_n) if (cur_len > 0) begin
    got_bits.push_back(cur_bits);
    got_len.push_back(cur_len);
    cur_len = 0;
  end

  // per-clock protocol checks against the R8/R9 rules
  always @(negedge clk) if (rst_n) begin
    if (spi_cs_n && spi_sclk) viol++;
    if (done && busy) viol++;
  end

  task automatic exp3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    exp_bits.push_back({56'd0, a, b, c});
    exp_len.push_back(3);
  endtask

  task automatic run(input bit wr, input logic [7:0] pg, input logic [7:0] rg,
                     input logic [3:0] len, input logic [63:0] wd, input logic [63:0] rv,
                     input int nbusy, input int nack, input bit inject, input string rq);
    logic [79:0] b;
    logic [63:0] mask;
    logic [1:0]  ecode;
    int          nfr;
    bit          lenok;
    stat_q.delete(); got_bits.delete(); got_len.delete();
    exp_bits.delete(); exp_len.delete();
    slave_rd = rv;
    lenok = (len == 1 || len == 2 || len == 4 || len == 6 || len == 8);
    for (int i = 0; i < nbusy; i++) stat_q.push_back(8'h80);
    if (nbusy < TRIES) stat_q.push_back(8'h00);
    if (!wr) for (int i = 0; i < nack; i++) stat_q.push_back(8'h00);
    ecode = 2'd0;
    if (!lenok) ecode = 2'd3;
    else begin
      for (int i = 0; i < ((nbusy + 1 < TRIES) ? nbusy + 1 : TRIES); i++) exp3(8'h60, 8'hFE, 8'h00);
      if (nbusy >= TRIES) ecode = 2'd1;
      else begin
        exp3(8'h61, 8'hFF, pg);
        if (wr) begin
          b = {64'd0, 8'h61, rg};
          for (int k = 0; k < int'(len); k++) b = {b[71:0], wd[8*k +: 8]};
          exp_bits.push_back(b); exp_len.push_back(2 + int'(len));
        end else begin
          exp3(8'h60, rg, 8'h00);
          for (int i = 0; i < ((nack + 1 < TRIES) ? nack + 1 : TRIES); i++) exp3(8'h60, 8'hFE, 8'h00);
          if (nack >= TRIES) ecode = 2'd2;
          else begin
            b = {64'd0, 8'h60, 8'hF0};
            for (int k = 0; k < int'(len); k++) b = {b[71:0], 8'h00};
            exp_bits.push_back(b); exp_len.push_back(2 + int'(len));
          end
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_page = pg; req_reg = rg;
    req_len = len; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    nfr = 0;
    while (!done) begin
      @(negedge clk);
      nfr++;
      if (inject && nfr == 40) begin
        req_valid = 1'b1; req_page = 8'hEE; req_write = ~wr; req_len = 4'd8;
      end else begin
        req_valid = 1'b0;
      end
    end
    chk(err == (ecode != 2'd0), rq, "err flag", 80'(err), 80'(ecode != 2'd0));
    chk(err_code == ecode, rq, "err_code", 80'(err_code), 80'(ecode));
    if (!wr && ecode == 2'd0) begin
      mask = (len == 4'd8) ? '1 : ((64'd1 << (8 * int'(len))) - 64'd1);
      chk(rd_data == (rv & mask), rq, "rd_data", 80'(rd_data), 80'(rv & mask));
    end
    repeat (30) @(negedge clk);
    chk(got_len.size() == exp_len.size(), rq, "frame count",
        80'(got_len.size()), 80'(exp_len.size()));
    for (int i = 0; i < exp_len.size() && i < got_len.size(); i++)
      chk(got_bits[i] == exp_bits[i] && got_len[i] == exp_len[i], rq, "frame bytes",
          got_bits[i], exp_bits[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 / R8: reset state
    chk(!busy && !done && !err, "R9", "reset flags", {77'd0, busy, done, err}, 80'd0);
    chk(spi_cs_n && !spi_sclk, "R8", "reset bus", {78'd0, spi_cs_n, spi_sclk}, 80'd2);

    run(1'b1, 8'h12, 8'h34, 4'd1, 64'h00000000000000A5, '0, 0, 0, 1'b0, "R4");
    run(1'b1, 8'h02, 8'h10, 4'd2, 64'h000000000000BEEF, '0, 0, 0, 1'b0, "R4");
    run(1'b1, 8'h05, 8'h20, 4'd6, 64'hFFFF112233445566, '0, 1, 0, 1'b0, "R4");
    run(1'b1, 8'h80, 8'h08, 4'd8, 64'h0123456789ABCDEF, '0, 2, 0, 1'b0, "R3");
    run(1'b0, 8'h01, 8'h00, 4'd1, '0, 64'h00000000000000C3, 0, 0, 1'b0, "R5");
    run(1'b0, 8'h21, 8'h44, 4'd4, '0, 64'h55667788DEADBEEF, 0, 3, 1'b0, "R6");
    run(1'b0, 8'h03, 8'h18, 4'd6, '0, 64'hFFFFFFFFFFFFFFFF, 1, 0, 1'b0, "R6");
    run(1'b0, 8'h7F, 8'hC0, 4'd8, '0, 64'h8877665544332211, 0, 1, 1'b0, "R1");
    run(1'b1, 8'h04, 8'h05, 4'd2, 64'h1234, '0, TRIES - 1, 0, 1'b0, "R2");
    run(1'b1, 8'h04, 8'h05, 4'd2, 64'h1234, '0, TRIES, 0, 1'b0, "R2");
    run(1'b0, 8'h09, 8'h0A, 4'd2, '0, 64'hAAAA, 0, TRIES - 1, 1'b0, "R5");
    run(1'b0, 8'h09, 8'h0A, 4'd2, '0, 64'hAAAA, 0, TRIES, 1'b0, "R5");
    run(1'b1, 8'h01, 8'h02, 4'd3, 64'h77, '0, 0, 0, 1'b0, "R7");
    run(1'b0, 8'h01, 8'h02, 4'd0, '0, 64'h77, 0, 0, 1'b0, "R7");
    run(1'b1, 8'h33, 8'h44, 4'd4, 64'hCAFEF00D, '0, 0, 0, 1'b1, "R9");
    chk(viol == 0, "R8", "per-clock select/clock/done rules", 80'(viol), 80'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule